// File: doc/BRIEF.md
# Ethernet Receive Fast-Path Classifier

This block watches the header words of each received Ethernet frame as they stream past. It compares them with values that software writes beforehand: the two MAC addresses, an ethertype and a flags word. It also compares them with an expected sequence number that the block holds itself. If every field agrees, the frame is a fast-path frame that hardware can handle alone, and the expected sequence number moves forward by one. If any field disagrees, the frame is marked slow-path so that the buffer holding it can flag it for firmware.

Header words arrive one 32-bit word per accepted cycle. The first word comes with a start-of-frame marker. Each word is compared as it arrives, and a single mismatch bit is kept between words, so no header is stored. The verdict comes out as a one-cycle pulse on the edge that accepts the sixth header word. A frame that ends before that word is marked slow-path. Software can also load the expected sequence number directly.

Top module: `fastpath_classifier`

## Requirements
- R1: After reset, `verdictValid`, `slowPath` and `expSeq` are 0, and all configuration values are 0. An all-zero header is therefore fast-path until software writes something.
- R2: A configuration write (`cfgWrEn`=1) stores `cfgWrData` by address. 0 is the flags word. 1 holds destination MAC bytes 0-3. 2 holds destination bytes 4-5 in bits 31:16 and source bytes 0-1 in bits 15:0. 3 holds source bytes 2-5. 4 holds the ethertype in bits 31:16. 5 loads the expected sequence number. The lowest-numbered byte of each field sits in the highest bits.
- R3: Header word k (counting from 0 at the word with `sofIn`) is compared as follows: k=0, 1 and 2 with addresses 1, 2 and 3; k=3 bits 31:16 with the ethertype; k=4 with the flags word; k=5 with `expSeq`. Only cycles with `wordValid`=1 advance k.
- R4: When all six header words match, `verdictValid` is 1 for one cycle, starting on the edge that accepts word 5, with `slowPath`=0.
- R5: A mismatch in any one of the six header words gives `slowPath`=1 in that verdict.
- R6: Bits 15:0 of header word 3 do not affect the verdict.
- R7: A fast-path verdict increments `expSeq` by one, wrapping at 2^32, on the same edge that raises `verdictValid`.
- R8: A slow-path verdict leaves `expSeq` unchanged.
- R9: `eofIn` on a header word before word 5 gives a verdict one edge later with `slowPath`=1. `eofIn` on word 5 gives the normal verdict.
- R10: Words after word 5, and words with no frame open and no `sofIn`, produce no verdict and leave `expSeq` unchanged.
- R11: `sofIn` during an unfinished header starts the header again at word 0 and discards the earlier mismatches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration register select |
| cfgWrData | input | 32 | Configuration write data |
| wordValid | input | 1 | A header word is present |
| wordData | input | 32 | Header word |
| sofIn | input | 1 | Word is the first of a frame |
| eofIn | input | 1 | Word is the last of a frame |
| verdictValid | output | 1 | One-cycle verdict pulse |
| slowPath | output | 1 | Verdict: 1 means the frame needs firmware |
| expSeq | output | 32 | Expected sequence number |

## Verification
The per-frame mismatch bit and the word index are the only hidden state. If either is wrong, the fault shows at the very next verdict as a wrong `slowPath` value, or as a verdict pulse on the wrong word. A wrong sequence update shows on `expSeq` on the verdict edge. A stale sequence value would then turn every later matching frame into slow-path, so the bench compares `expSeq` after every frame. Frames with one corrupted field, frames with idle gaps, short frames, restarted frames and trailing words each expose a different one of these paths.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int HDR_WORDS = 6;
  localparam int LAST_IDX  = HDR_WORDS - 1;
  localparam int IDX_W     = $clog2(HDR_WORDS);

  typedef enum logic [2:0] {
    CFG_FLAGS = 3'd0,
    CFG_DST   = 3'd1,
    CFG_MIX   = 3'd2,
    CFG_SRC   = 3'd3,
    CFG_ETYPE = 3'd4,
    CFG_SEQ   = 3'd5
  } cfgAddr_e;

  typedef struct packed {
    logic             take;
    logic [IDX_W-1:0] idx;
    logic             decide;
    logic             abort;
  } fpcStrobes_t;
endpackage

// File: rtl/fpc_ctrl.sv
module fpc_ctrl
  import fpc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wordValid,
  input  logic        sofIn,
  input  logic        eofIn,
  output fpcStrobes_t st
);
  logic             active;
  logic [IDX_W-1:0] nextIdx;
  logic [IDX_W-1:0] curIdx;

  always_comb begin
    curIdx    = sofIn ? '0 : nextIdx;
    st.take   = wordValid && (sofIn || active);
    st.idx    = curIdx;
    st.decide = st.take && (curIdx == IDX_W'(LAST_IDX));
    st.abort  = st.take && eofIn && !st.decide;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      nextIdx <= '0;
    end else if (st.take) begin
      if (st.decide || st.abort) begin
        active  <= 1'b0;
        nextIdx <= '0;
      end else begin
        active  <= 1'b1;
        nextIdx <= curIdx + 1'b1;
      end
    end
  end

  // R3: index never runs past the verdict word while a frame is open
  a_r3_index_bound: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (nextIdx <= IDX_W'(LAST_IDX)));
endmodule

// File: rtl/fpc_dp.sv
module fpc_dp
  import fpc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  fpcStrobes_t       st,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic [DATA_W-1:0] wordData,
  output logic              verdictValid,
  output logic              slowPath,
  output logic [DATA_W-1:0] expSeq
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] cfgFlags, cfgDst, cfgMix, cfgSrc;
  logic [HALF_W-1:0] cfgEtype;
  logic              misAcc, misPrev, wordMis, seqLoad;

  always_comb begin
    seqLoad = cfgWrEn && (cfgAddr == CFG_SEQ);
    misPrev = (st.idx == '0) ? 1'b0 : misAcc;
    case (st.idx)
      IDX_W'(0): wordMis = wordData != cfgDst;
      IDX_W'(1): wordMis = wordData != cfgMix;
      IDX_W'(2): wordMis = wordData != cfgSrc;
      IDX_W'(3): wordMis = wordData[DATA_W-1 -: HALF_W] != cfgEtype;
      IDX_W'(4): wordMis = wordData != cfgFlags;
      default:   wordMis = wordData != expSeq;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgFlags     <= '0;
      cfgDst       <= '0;
      cfgMix       <= '0;
      cfgSrc       <= '0;
      cfgEtype     <= '0;
      expSeq       <= '0;
      misAcc       <= 1'b0;
      verdictValid <= 1'b0;
      slowPath     <= 1'b0;
    end else begin
      verdictValid <= 1'b0;
      if (cfgWrEn) begin
        case (cfgAddr)
          CFG_FLAGS: cfgFlags <= cfgWrData;
          CFG_DST:   cfgDst   <= cfgWrData;
          CFG_MIX:   cfgMix   <= cfgWrData;
          CFG_SRC:   cfgSrc   <= cfgWrData;
          CFG_ETYPE: cfgEtype <= cfgWrData[DATA_W-1 -: HALF_W];
          CFG_SEQ:   expSeq   <= cfgWrData;
          default: ;
        endcase
      end
      if (st.take) misAcc <= misPrev | wordMis;
      if (st.decide) begin
        verdictValid <= 1'b1;
        slowPath     <= misPrev | wordMis;
        if (!(misPrev | wordMis) && !seqLoad) expSeq <= expSeq + 1'b1;
      end
      if (st.abort) begin
        verdictValid <= 1'b1;
        slowPath     <= 1'b1;
      end
    end
  end

  a_r7_seq_advance: assert property (@(posedge clk) disable iff (!rstN)
    (verdictValid && !slowPath && !$past(seqLoad)) |-> (expSeq == $past(expSeq) + 1'b1));
  a_r8_seq_hold: assert property (@(posedge clk) disable iff (!rstN)
    (verdictValid && slowPath && !$past(seqLoad)) |-> $stable(expSeq));
  a_r10_seq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!verdictValid && !$past(seqLoad)) |-> $stable(expSeq));
  a_r9_short_slow: assert property (@(posedge clk) disable iff (!rstN)
    st.abort |=> (verdictValid && slowPath));
  a_r10_no_take_no_verdict: assert property (@(posedge clk) disable iff (!rstN)
    !st.take |=> !verdictValid);
endmodule

// File: rtl/fastpath_classifier.sv
module fastpath_classifier
  import fpc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              wordValid,
  input  logic [DATA_W-1:0] wordData,
  input  logic              sofIn,
  input  logic              eofIn,
  output logic              verdictValid,
  output logic              slowPath,
  output logic [DATA_W-1:0] expSeq
);
  fpcStrobes_t st;

  fpc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wordValid(wordValid),
    .sofIn(sofIn), .eofIn(eofIn), .st(st)
  );

  fpc_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .wordData(wordData), .verdictValid(verdictValid),
    .slowPath(slowPath), .expSeq(expSeq)
  );
endmodule

// File: tb/fastpath_classifier_bench.sv
module fastpath_classifier_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic        wordValid = 1'b0;
  logic [31:0] wordData = '0;
  logic        sofIn = 1'b0;
  logic        eofIn = 1'b0;
  logic        verdictValid, slowPath;
  logic [31:0] expSeq;

  int testCount = 0;
  int failCount = 0;
  bit finished = 0;

  logic [47:0] dstMac = '0, srcMac = '0;
  logic [15:0] etype = '0;
  logic [31:0] flagsW = '0, seqModel = '0;
  logic [31:0] hdr [6];

  always #(CLK_PERIOD/2) clk = ~clk;

  fastpath_classifier u_fastpath_classifier (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .wordValid(wordValid), .wordData(wordData),
    .sofIn(sofIn), .eofIn(eofIn), .verdictValid(verdictValid),
    .slowPath(slowPath), .expSeq(expSeq)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] a, input logic [31:0] d);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic writeAllCfg();
    cfgWrite(3'd1, dstMac[47:16]);
    cfgWrite(3'd2, {dstMac[15:0], srcMac[47:32]});
    cfgWrite(3'd3, srcMac[31:0]);
    cfgWrite(3'd4, {etype, 16'h0});
    cfgWrite(3'd0, flagsW);
    cfgWrite(3'd5, seqModel);
  endtask

  function automatic logic [31:0] modelWord(input int k, input logic [15:0] pad);
    case (k)
      0: modelWord = dstMac[47:16];
      1: modelWord = {dstMac[15:0], srcMac[47:32]};
      2: modelWord = srcMac[31:0];
      3: modelWord = {etype, pad};
      4: modelWord = flagsW;
      default: modelWord = seqModel;
    endcase
  endfunction

  task automatic buildHdr(input logic [15:0] pad);
    for (int k = 0; k < 6; k++) hdr[k] = modelWord(k, pad);
  endtask

  task automatic putWord(input logic [31:0] d, input logic s, input logic e);
    wordValid = 1'b1; wordData = d; sofIn = s; eofIn = e;
    @(negedge clk);
    wordValid = 1'b0; sofIn = 1'b0; eofIn = 1'b0;
  endtask

  task automatic sendHdr(input int n, input bit eofLast, input bit gaps);
    for (int i = 0; i < n; i++) begin
      putWord(hdr[i], i == 0, eofLast && (i == n - 1));
      if (gaps && i < n - 1 && ($urandom % 3 == 0)) @(negedge clk);
    end
  endtask

  task automatic checkVerdict(input bit expSlow, input string req);
    chk(verdictValid === 1'b1, {req, " verdict pulse"}, verdictValid, 1);
    chk(slowPath === expSlow, {req, " slow flag"}, slowPath, expSlow);
    chk(expSeq === seqModel, {req, " expSeq"}, expSeq, seqModel);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    logic [31:0] saveSeq;
    seedDummy = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state and zero configuration
    chk(verdictValid === 1'b0, "R1 verdictValid", verdictValid, 0);
    chk(slowPath === 1'b0, "R1 slowPath", slowPath, 0);
    chk(expSeq === 32'd0, "R1 expSeq", expSeq, 0);
    buildHdr(16'h0);
    sendHdr(6, 1'b1, 1'b0);
    seqModel++;
    checkVerdict(1'b0, "R1 zero header fast");

    // R2 R4 R7 configured match
    dstMac = 48'h0A1B2C3D4E5F; srcMac = 48'h665544332211;
    etype = 16'h88B5; flagsW = 32'hC0DE0001; seqModel = 32'h100;
    writeAllCfg();
    chk(expSeq === 32'h100, "R2 seq load", expSeq, 32'h100);
    buildHdr(16'h0);
    sendHdr(6, 1'b1, 1'b0);
    seqModel++;
    checkVerdict(1'b0, "R4 R7 fast match");
    @(negedge clk);
    chk(verdictValid === 1'b0, "R4 single pulse", verdictValid, 0);

    // R5 R8 each field corrupted
    for (int f = 0; f < 6; f++) begin
      buildHdr(16'h0);
      hdr[f] = hdr[f] ^ ((f == 3) ? 32'h0001_0000 : 32'h0000_0100);
      sendHdr(6, 1'b1, 1'b0);
      checkVerdict(1'b1, "R5 R8 field mismatch");
    end

    // R6 pad bits ignored
    buildHdr(16'hBEEF);
    sendHdr(6, 1'b0, 1'b0);
    seqModel++;
    checkVerdict(1'b0, "R6 pad ignored");

    // R9 short frames
    buildHdr(16'h0);
    sendHdr(3, 1'b1, 1'b0);
    checkVerdict(1'b1, "R9 eof on word 2");
    sendHdr(1, 1'b1, 1'b0);
    checkVerdict(1'b1, "R9 eof on word 0");
    sendHdr(6, 1'b1, 1'b0);
    seqModel++;
    checkVerdict(1'b0, "R9 eof on word 5");

    // R10 trailing and stray words
    buildHdr(16'h0);
    sendHdr(6, 1'b0, 1'b0);
    seqModel++;
    checkVerdict(1'b0, "R10 lead frame");
    for (int i = 0; i < 6; i++) begin
      putWord(modelWord(i, 16'h0), 1'b0, i == 5);
      chk(verdictValid === 1'b0, "R10 no verdict", verdictValid, 0);
      chk(expSeq === seqModel, "R10 seq unchanged", expSeq, seqModel);
    end

    // R11 restart on sof mid header
    buildHdr(16'h0);
    hdr[1] = ~hdr[1];
    sendHdr(3, 1'b0, 1'b0);
    buildHdr(16'h0);
    sendHdr(6, 1'b0, 1'b0);
    seqModel++;
    checkVerdict(1'b0, "R11 restart");

    // R7 wrap
    seqModel = 32'hFFFF_FFFF;
    cfgWrite(3'd5, seqModel);
    buildHdr(16'h0);
    sendHdr(6, 1'b1, 1'b0);
    seqModel = 32'h0;
    checkVerdict(1'b0, "R7 wrap");

    // random mix with new configuration
    dstMac = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
    srcMac = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
    etype = 16'($urandom); flagsW = $urandom; seqModel = $urandom;
    writeAllCfg();
    for (int n = 0; n < 200; n++) begin
      int kind;
      kind = $urandom % 9;
      buildHdr(16'($urandom));
      if (kind < 6) hdr[kind] = hdr[kind] ^ ((kind == 3) ? (32'h1 << (16 + $urandom % 16)) : (32'h1 << ($urandom % 32)));
      saveSeq = seqModel;
      sendHdr(6, 1'($urandom % 2), 1'b1);
      if (kind >= 6) seqModel = saveSeq + 1;
      checkVerdict(kind < 6, kind < 6 ? "R5 R8 random" : "R4 R7 random");
      if ($urandom % 4 == 0) @(negedge clk);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule